// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block moves one data operand between memory and a numeric coprocessor. The core loads an operand address and a transfer direction ahead of time. When the coprocessor raises its asynchronous request line, the block synchronises the request and issues two back-to-back bus operations through a level-held request port. An external cycle sequencer (status state plus command states, with any number of wait states) completes each operation and signals this with a one-cycle completion strobe.

One operation is a memory access at the operand address. The other is an I/O access at the fixed coprocessor data port, hex 00FA. The direction decides their order. An acknowledge to the coprocessor is held only for the first operation. After the second operation the block emits a one-cycle done pulse. It then ignores the request line for a short hold-off window, so that a request the coprocessor has not yet withdrawn does not start a spurious second transfer. A request that is still present after the window does start another transfer.

Top module: `cop_xfer_seq`

## Requirements
- R1: While and directly after synchronous reset, `bus_req`, `cop_ack` and `seq_done` are low.
- R2: `cop_req` passes through a two-stage synchroniser. If it is first sampled high at clock edge n while the block is idle and outside the hold-off window, `bus_req` is high after edge n+2.
- R3: With `ld_dir`=1 (coprocessor to memory), the first operation is an I/O read (`bus_mio`=0, `bus_wr`=0) at address 0x00FA. The second is a memory write (`bus_mio`=1, `bus_wr`=1) at the operand address.
- R4: With `ld_dir`=0 (memory to coprocessor), the first operation is a memory read (`bus_mio`=1, `bus_wr`=0) at the operand address. The second is an I/O write (`bus_mio`=0, `bus_wr`=1) at 0x00FA.
- R5: `cop_ack` is high from the cycle `bus_req` rises until the edge at which `bus_done` completes the first operation, and at no other time.
- R6: Each operation holds `bus_req`, `bus_addr`, `bus_mio` and `bus_wr` steady until `bus_done` is sampled high. The second operation is presented in the very next cycle, with no idle cycle between.
- R7: `seq_done` is high for exactly one cycle, directly after the edge that completes the second operation.
- R8: Requests are ignored during a sequence and for HOLDOFF (default 3) cycles after `seq_done`. A request still held after that starts a new sequence.
- R9: The operand address and direction are captured when a sequence starts. A load during a sequence leaves that sequence unchanged and applies to the next one.
- R10: A `bus_done` pulse while no operation is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cop_req | input | 1 | Asynchronous transfer request from the coprocessor |
| ld_en | input | 1 | Load strobe for operand address and direction |
| ld_addr | input | AW | Operand memory address to load |
| ld_dir | input | 1 | 1 = coprocessor to memory, 0 = memory to coprocessor |
| bus_req | output | 1 | Bus operation requested, held until completion |
| bus_addr | output | AW | Address of the current operation |
| bus_mio | output | 1 | 1 = memory space, 0 = I/O space |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_done | input | 1 | One-cycle completion strobe from the cycle sequencer |
| cop_ack | output | 1 | Acknowledge to the coprocessor during the first operation |
| seq_done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
A corrupted phase register would show at once as a wrong `bus_mio`/`bus_wr` pairing or a misplaced `cop_ack`, in the same cycle the faulty state is entered. A bad captured address or direction shows on `bus_addr` for the whole of an operation. Hold-off or synchroniser faults show as `bus_req` rising one or more cycles early or late relative to the request, or as an extra transfer after a lingering request. The bench compares every output against a behavioural model on every cycle, so any such deviation is caught in the cycle it first appears.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;
endpackage

// File: rtl/cxs_sync.sv
module cxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh_q[i] <= 1'b0;
      else     sh_q[i] <= sh_q[i-1];
    end
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cxs_holdoff.sv
module cxs_holdoff #(
  parameter int HOLDOFF = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic open_win
);
  localparam int CW = $clog2(HOLDOFF + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (arm)          cnt_q <= CW'(HOLDOFF);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign open_win = (cnt_q == '0);

  // R8
  holdoff_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cxs_fsm.sv
module cxs_fsm
  import cxs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_s,
  input  logic   window_open,
  input  logic   bus_done,
  output phase_t phase,
  output logic   start,
  output logic   seq_end,
  output logic   done_pulse
);
  phase_t phase_q;
  logic   done_q;

  assign start   = (phase_q == PH_IDLE) && req_s && window_open;
  assign seq_end = (phase_q == PH_SECOND) && bus_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= seq_end;
      case (phase_q)
        PH_IDLE:   if (start)    phase_q <= PH_FIRST;
        PH_FIRST:  if (bus_done) phase_q <= PH_SECOND;
        PH_SECOND: if (bus_done) phase_q <= PH_IDLE;
        default:                 phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign done_pulse = done_q;

  // R8
  closed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !window_open) |=> (phase_q == PH_IDLE));
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !req_s && bus_done) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
  import cxs_pkg::*;
#(
  parameter int AW          = 24,
  parameter int PORT_ADDR   = 'h00FA,
  parameter int HOLDOFF     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cop_req,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_dir,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mio,
  output logic          bus_wr,
  input  logic          bus_done,
  output logic          cop_ack,
  output logic          seq_done
);
  localparam logic [AW-1:0] PORT_VAL = AW'(PORT_ADDR);

  logic          req_s, win_open, start, seq_end;
  phase_t        phase;
  logic [AW-1:0] op_addr_q, cur_addr_q;
  logic          op_dir_q, cur_dir_q;

  cxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cop_req), .dout(req_s));

  cxs_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
    .clk(clk), .rst(rst), .arm(seq_end), .open_win(win_open));

  cxs_fsm u_fsm (
    .clk(clk), .rst(rst), .req_s(req_s), .window_open(win_open),
    .bus_done(bus_done), .phase(phase), .start(start),
    .seq_end(seq_end), .done_pulse(seq_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_addr_q <= '0;
      op_dir_q  <= 1'b0;
    end else if (ld_en) begin
      op_addr_q <= ld_addr;
      op_dir_q  <= ld_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr_q <= '0;
      cur_dir_q  <= 1'b0;
    end else if (start) begin
      cur_addr_q <= op_addr_q;
      cur_dir_q  <= op_dir_q;
    end
  end

  always_comb begin
    bus_req = (phase != PH_IDLE);
    cop_ack = (phase == PH_FIRST);
    bus_wr  = (phase == PH_SECOND);
    if (phase == PH_FIRST) begin
      bus_addr = cur_dir_q ? PORT_VAL : cur_addr_q;
      bus_mio  = !cur_dir_q;
    end else begin
      bus_addr = cur_dir_q ? cur_addr_q : PORT_VAL;
      bus_mio  = cur_dir_q;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_req && !cop_ack && !seq_done));
  // R5
  ack_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    cop_ack |-> (bus_req && !bus_wr));
  // R5
  ack_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> cop_ack);
  // R6
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_mio) && $stable(bus_wr)));
  // R6
  second_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (cop_ack && bus_done) |=> (bus_req && bus_wr && !cop_ack));
  // R3, R4
  port_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_mio) |-> (bus_addr == PORT_VAL));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_done) |=> (seq_done && !bus_req));
endmodule

// File: tb/sim_cop_xfer_seq.sv
module sim_cop_xfer_seq;
  localparam int AW   = 24;
  localparam int HOLD = 3;
  localparam logic [AW-1:0] PORT = 24'h0000FA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cop_req = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_dir = 1'b0;
  logic          bus_req, bus_mio, bus_wr, cop_ack, seq_done;
  logic [AW-1:0] bus_addr;
  logic          bus_done = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  cop_xfer_seq #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cop_req(cop_req), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_dir(ld_dir), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_mio(bus_mio), .bus_wr(bus_wr),
    .bus_done(bus_done), .cop_ack(cop_ack), .seq_done(seq_done));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_s1, m_s2, m_done, m_od, m_cd, t_s2;
  int m_ph, m_cnt, t_ph, t_cnt;
  logic [AW-1:0] m_oa, m_ca;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_done = 0; m_od = 0; m_cd = 0;
      m_ph = 0; m_cnt = 0; m_oa = '0; m_ca = '0;
    end else begin
      t_s2 = m_s2; t_ph = m_ph; t_cnt = m_cnt;
      m_s2 = m_s1; m_s1 = cop_req;
      m_done = (t_ph == 2 && bus_done);
      if (t_ph == 0 && t_s2 && t_cnt == 0) begin
        m_ph = 1; m_ca = m_oa; m_cd = m_od;
      end else if (t_ph == 1 && bus_done) m_ph = 2;
      else if (t_ph == 2 && bus_done) m_ph = 0;
      if (t_ph == 2 && bus_done) m_cnt = HOLD;
      else if (t_cnt != 0) m_cnt = t_cnt - 1;
      if (ld_en) begin m_oa = ld_addr; m_od = ld_dir; end
    end
  end

  // bus model with random wait states, plus per-cycle comparison
  logic [AW+1:0] oplog[$];
  bit busy = 0, stray = 0;
  int wcnt = 0;
  logic [AW-1:0] e_addr;
  bit e_mio;

  always @(negedge clk) begin
    if (!rst) begin
      e_addr = (m_ph == 1) ? (m_cd ? PORT : m_ca) : (m_cd ? m_ca : PORT);
      e_mio  = (m_ph == 1) ? !m_cd : m_cd;
      chk(bus_req === (m_ph != 0), "R2 bus_req", 32'(bus_req), 32'(m_ph != 0));
      chk(cop_ack === (m_ph == 1), "R5 cop_ack", 32'(cop_ack), 32'(m_ph == 1));
      chk(seq_done === m_done, "R7 seq_done", 32'(seq_done), 32'(m_done));
      if (m_ph != 0) begin
        chk(bus_addr === e_addr, "R6 bus_addr", 32'(bus_addr), 32'(e_addr));
        chk(bus_mio === e_mio, "R6 bus_mio", 32'(bus_mio), 32'(e_mio));
        chk(bus_wr === (m_ph == 2), "R6 bus_wr", 32'(bus_wr), 32'(m_ph == 2));
      end
    end
    if (bus_done) bus_done = 1'b0;
    else if (bus_req) begin
      if (!busy) begin
        busy = 1;
        wcnt = $urandom_range(0, 3);
        oplog.push_back({bus_mio, bus_wr, bus_addr});
      end
      if (wcnt == 0) begin bus_done = 1'b1; busy = 0; end
      else wcnt--;
    end else if (stray) begin
      bus_done = 1'b1;
      stray = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (seq_done) break;
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input bit d);
    @(negedge clk);
    ld_en = 1; ld_addr = a; ld_dir = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic pulse_req(input int n);
    cop_req = 1;
    repeat (n) @(negedge clk);
    cop_req = 0;
  endtask

  task automatic check_pair(input logic [AW-1:0] a, input bit d, input string tag);
    logic [AW+1:0] e1, e2, g;
    e1 = d ? {1'b0, 1'b0, PORT} : {1'b1, 1'b0, a};
    e2 = d ? {1'b1, 1'b1, a} : {1'b0, 1'b1, PORT};
    chk(oplog.size() == 2, {tag, " op count"}, 32'(oplog.size()), 2);
    if (oplog.size() >= 2) begin
      g = oplog.pop_front();
      chk(g === e1, {tag, " first op"}, 32'(g), 32'(e1));
      g = oplog.pop_front();
      chk(g === e2, {tag, " second op"}, 32'(g), 32'(e2));
    end
    oplog.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!bus_req && !cop_ack && !seq_done, "R1 outputs in reset", {bus_req, cop_ack, seq_done}, 0);
    rst = 0;
    @(negedge clk);
    chk(!bus_req && !cop_ack && !seq_done, "R1 outputs after reset", {bus_req, cop_ack, seq_done}, 0);

    // R4 and R2: memory to coprocessor with exact start latency
    load(24'h123456, 1'b0);
    cop_req = 1;
    @(negedge clk);
    chk(!bus_req, "R2 not yet started (1)", 32'(bus_req), 0);
    @(negedge clk);
    chk(!bus_req, "R2 not yet started (2)", 32'(bus_req), 0);
    cop_req = 0;
    @(negedge clk);
    chk(bus_req && cop_ack, "R2 started", {bus_req, cop_ack}, 3);
    wait_done();
    repeat (HOLD + 4) @(negedge clk);
    check_pair(24'h123456, 1'b0, "R4");

    // R3: coprocessor to memory
    load(24'hABCDE0, 1'b1);
    pulse_req(2);
    wait_done();
    repeat (HOLD + 4) @(negedge clk);
    check_pair(24'hABCDE0, 1'b1, "R3");

    // R9: load during a sequence affects only the next one
    load(24'h000111, 1'b0);
    cop_req = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_req) break;
    end
    cop_req = 0;
    ld_en = 1; ld_addr = 24'hFEDCBA; ld_dir = 1;
    @(negedge clk);
    ld_en = 0;
    wait_done();
    repeat (HOLD + 4) @(negedge clk);
    check_pair(24'h000111, 1'b0, "R9 current");
    pulse_req(2);
    wait_done();
    repeat (HOLD + 4) @(negedge clk);
    check_pair(24'hFEDCBA, 1'b1, "R9 next");

    // R8: short request inside hold-off window is ignored
    pulse_req(2);
    wait_done();
    pulse_req(1);
    repeat (12) @(negedge clk);
    chk(!bus_req, "R8 ignored in window", 32'(bus_req), 0);
    check_pair(24'hFEDCBA, 1'b1, "R8 single transfer");

    // R8: lingering request starts a second transfer after the window
    load(24'h0C0C0C, 1'b0);
    cop_req = 1;
    wait_done();
    wait_done();
    cop_req = 0;
    repeat (14) @(negedge clk);
    chk(oplog.size() == 4, "R8 two transfers", 32'(oplog.size()), 4);
    chk(!bus_req, "R8 no third transfer", 32'(bus_req), 0);
    oplog.delete();

    // R10: stray completion strobe while idle
    stray = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bus_req && !seq_done, "R10 stray bus_done", {bus_req, seq_done}, 0);
    end
    chk(oplog.size() == 0, "R10 no operation", 32'(oplog.size()), 0);

    // several more back-to-back transfers in both directions
    for (int k = 0; k < 6; k++) begin
      load(AW'(24'h100000 + k * 24'h11), k[0]);
      pulse_req(1 + k % 3);
      wait_done();
      repeat (HOLD + 4) @(negedge clk);
      check_pair(AW'(24'h100000 + k * 24'h11), k[0], k[0] ? "R3 loop" : "R4 loop");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule